// File: doc/BRIEF.md
# Calendar Clock with Shadow-Buffered Host Access

This block keeps a running calendar: seconds, minutes, hours, a one-hot weekday, month, a two-digit year and the day of the month. All of them advance on a one-cycle pulse of the `tick_1s` input. A byte-wide synchronous register bus never touches the running counters directly. Every host access goes through a seven-byte shadow buffer. The host triggers one of two transfers through an update register. A commit copies the buffer into the live counters. A snapshot copies the live counters into the buffer. Each transfer runs through a fixed settling window, and `busy` is high for the whole window.

The transfer sequencer is a five-state machine. `ST_IDLE` moves to `ST_WR_WAIT` when the update register is written with bit 0 set. It moves to `ST_RD_WAIT` when the update register is written with bit 4 set and bit 0 clear. Each wait state counts `SETTLE_CYC` cycles and then steps to its action state. `ST_WAIT_WR` is not a state name; the action states are `ST_WR_COMMIT` (the live counters load from the buffer) and `ST_RD_GRAB` (the buffer loads from the live counters). Each action state returns to `ST_IDLE` after one cycle.

The hour is kept internally as 0 to 23. It is converted to or from the host format of the moment on each transfer. The block also drives a one-cycle `min_event` pulse whenever the seconds wrap, for use by interrupt logic.

Top module: `cal_rtc_regs`

## Requirements
- R1: After reset the register values are as follows.
  - Mask register (0x0) reads 0x00.
  - Control register (0x1) reads 0x02.
  - Update register (0x2) reads 0x00.
  - `busy` is low.
  - The buffer reads sec 0, min 0, hour 0, weekday 0x01, month 1, year 0, date 1.
- R2: A write to control address 0x1 changes only the bits that are set in mask address 0x0. Both registers have two bits and read back zero-extended. Control bit 1 set selects 24-hour format. Bit 0 is a stored mode flag.
- R3: Writing 1 to bit 0 of update address 0x2 loads the live counters from the buffer. The load happens when the settling window ends.
- R4: Writing 1 to bit 4 of address 0x2 with bit 0 clear copies the live counters into the buffer. If both bits are written as 1, only the buffer-to-counter commit runs.
- R5: Once a transfer has been started, `busy` is high for exactly SETTLE_CYC+1 cycles.
  - While the transfer runs, address 0x2 reads 0x01 for a commit and 0x10 for a snapshot.
  - Both bits read 0 once it completes.
- R6: Writes to address 0x2 while `busy` is high are ignored.
- R7: Seconds and minutes wrap 59 to 0, and hours wrap 23 to 0, each carrying into the next field. `min_event` is high for one cycle, the cycle after the tick that wraps the seconds.
- R8: At midnight the one-hot weekday rotates left (bit 6 goes to bit 0) and the date advances.
- R9: Month lengths follow these rules:
  - April, June, September and November have 30 days.
  - February has 29 days when year mod 4 is 0, and 28 otherwise.
  - All other months have 31 days.
  - December rolls over to January with year+1, and year 99 rolls over to 0.
- R10: The hour field depends on the format.
  - In 24-hour format it is 0 to 23 in bits 4:0.
  - In 12-hour format it is 1 to 12 in bits 3:0, with bit 6 set for PM. 12 AM means hour 0 and 12 PM means hour 12.
  - The conversion uses the format in force at each transfer.
- R11: The buffer fields sit at consecutive addresses, in this order: sec 0x4, min 0x5, hour 0x6, weekday 0x7, month 0x8, year 0x9, date 0xA. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| busy | output | 1 | A transfer is in its settling window |
| min_event | output | 1 | Seconds wrapped on the previous tick |

## Verification
The assertions check several properties on every cycle:
- The `busy` window has the exact length given in R5.
- The update bits clear when the sequencer is idle.
- Writes to the update register during a transfer leave the pending bits unchanged.
- `min_event` is a single-cycle pulse that coincides with seconds at zero.
- The weekday rotates at each midnight.

Only the bench scenarios can show that values survive the buffer round trip. The same holds for calendar carries across month ends, leap Februaries and the year-99 wrap, the 12/24-hour conversion, and the masked control writes.

// File: rtl/cal_rtc_pkg.sv
`timescale 1ns/1ps
package cal_rtc_pkg;

    localparam int FIELD_N  = 7;
    localparam int A_MASK   = 0;
    localparam int A_CTRL   = 1;
    localparam int A_UPD    = 2;
    localparam int A_TIME0  = 4;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [6:0] wday;
        logic [3:0] mon;
        logic [6:0] year;
        logic [4:0] date;
    } cal_time_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_COMMIT,
        ST_RD_WAIT,
        ST_RD_GRAB
    } xfer_state_e;

    // Last day of a month; leap rule is year mod 4 == 0.
    function automatic logic [4:0] month_last_day(input logic [3:0] mon, input logic [6:0] year);
        logic [4:0] d;
        unique case (mon)
            4'd2:                      d = (year[1:0] == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

    // Host hour byte to internal 0..23 hour.
    function automatic logic [4:0] host_to_hour(input logic [7:0] f, input logic mode24);
        logic [4:0] base;
        if (mode24) return f[4:0];
        base = (f[3:0] == 4'd12) ? 5'd0 : {1'b0, f[3:0]};
        return f[6] ? base + 5'd12 : base;
    endfunction

    // Internal 0..23 hour to host hour byte.
    function automatic logic [7:0] hour_to_host(input logic [4:0] h, input logic mode24);
        logic       pm;
        logic [4:0] hh;
        if (mode24) return {3'b000, h};
        pm = (h >= 5'd12);
        hh = pm ? h - 5'd12 : h;
        if (hh == 5'd0) hh = 5'd12;
        return {1'b0, pm, 2'b00, hh[3:0]};
    endfunction

endpackage

// File: rtl/cal_rtc_clock.sv
`timescale 1ns/1ps
module cal_rtc_clock
    import cal_rtc_pkg::*;
#(
    parameter int YEAR_TOP = 99
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t live,
    output logic      min_pulse
);
    localparam logic [5:0] SEC_TOP  = 6'd59;
    localparam logic [5:0] MIN_TOP  = 6'd59;
    localparam logic [4:0] HOUR_TOP = 5'd23;
    localparam logic [3:0] MON_TOP  = 4'd12;
    localparam logic [6:0] YR_TOP   = 7'(YEAR_TOP);

    cal_time_t live_q, live_d;
    logic      pulse_q;

    always_comb begin
        live_d = live_q;
        if (tick) begin
            if (live_q.sec != SEC_TOP) begin
                live_d.sec = live_q.sec + 6'd1;
            end else begin
                live_d.sec = '0;
                if (live_q.min != MIN_TOP) begin
                    live_d.min = live_q.min + 6'd1;
                end else begin
                    live_d.min = '0;
                    if (live_q.hour != HOUR_TOP) begin
                        live_d.hour = live_q.hour + 5'd1;
                    end else begin
                        live_d.hour = '0;
                        live_d.wday = {live_q.wday[5:0], live_q.wday[6]};
                        if (live_q.date < month_last_day(live_q.mon, live_q.year)) begin
                            live_d.date = live_q.date + 5'd1;
                        end else begin
                            live_d.date = 5'd1;
                            if (live_q.mon < MON_TOP) begin
                                live_d.mon = live_q.mon + 4'd1;
                            end else begin
                                live_d.mon  = 4'd1;
                                live_d.year = (live_q.year >= YR_TOP) ? 7'd0 : live_q.year + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 7'h01,
                         mon: 4'd1, year: 7'd0, date: 5'd1};
            pulse_q <= 1'b0;
        end else if (load) begin
            live_q  <= load_val;
            pulse_q <= 1'b0;
        end else begin
            live_q  <= live_d;
            pulse_q <= tick && (live_q.sec == SEC_TOP);
        end
    end

    assign live      = live_q;
    assign min_pulse = pulse_q;

endmodule

// File: rtl/cal_rtc_xfer.sv
`timescale 1ns/1ps
module cal_rtc_xfer
    import cal_rtc_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_wr,
    input  logic [7:0] upd_data,
    output logic       busy,
    output logic [1:0] pend,
    output logic       load_pulse,
    output logic       grab_pulse,
    output logic       done
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (upd_wr && upd_data[0])      state_d = ST_WR_WAIT;
                else if (upd_wr && upd_data[4]) state_d = ST_RD_WAIT;
            end
            ST_WR_WAIT:   if (cnt_q == CNT_LAST) state_d = ST_WR_COMMIT;
            ST_RD_WAIT:   if (cnt_q == CNT_LAST) state_d = ST_RD_GRAB;
            ST_WR_COMMIT: state_d = ST_IDLE;
            ST_RD_GRAB:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        busy       = 1'b1;
        pend       = 2'b00;
        load_pulse = 1'b0;
        grab_pulse = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_WR_WAIT:   pend = 2'b01;
            ST_RD_WAIT:   pend = 2'b10;
            ST_WR_COMMIT: begin pend = 2'b01; load_pulse = 1'b1; done = 1'b1; end
            ST_RD_GRAB:   begin pend = 2'b10; grab_pulse = 1'b1; done = 1'b1; end
            default:      busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/cal_rtc_regs.sv
`timescale 1ns/1ps
module cal_rtc_regs
    import cal_rtc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int SETTLE_CYC = 4,
    parameter int YEAR_TOP   = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              min_event
);
    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0]         mask_q, ctrl_q;
    logic [FIELD_N-1:0][7:0]   buf_q;
    logic [FIELD_N-1:0][7:0]   snap;
    logic [FIELD_N-1:0]        fld_we;
    logic                      upd_wr, load_w, grab_w, done_w;
    logic [1:0]                pend_w;
    cal_time_t                 live_w, load_val;
    logic                      mode24;

    assign mode24 = ctrl_q[1];
    assign upd_wr = bus_wr && (bus_addr == ADDR_W'(A_UPD));

    for (genvar i = 0; i < FIELD_N; i++) begin : g_fld
        assign fld_we[i] = bus_wr && (bus_addr == ADDR_W'(A_TIME0 + i));
    end

    // Live counters to host byte layout.
    assign snap[0] = {2'b00, live_w.sec};
    assign snap[1] = {2'b00, live_w.min};
    assign snap[2] = hour_to_host(live_w.hour, mode24);
    assign snap[3] = {1'b0, live_w.wday};
    assign snap[4] = {4'b0000, live_w.mon};
    assign snap[5] = {1'b0, live_w.year};
    assign snap[6] = {3'b000, live_w.date};

    // Host byte layout to live counters.
    assign load_val.sec  = buf_q[0][5:0];
    assign load_val.min  = buf_q[1][5:0];
    assign load_val.hour = host_to_hour(buf_q[2], mode24);
    assign load_val.wday = buf_q[3][6:0];
    assign load_val.mon  = buf_q[4][3:0];
    assign load_val.year = buf_q[5][6:0];
    assign load_val.date = buf_q[6][4:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= CTRL_W'(2'b10);
            buf_q  <= {8'd1, 8'd0, 8'd1, 8'h01, 8'd0, 8'd0, 8'd0};
        end else begin
            if (bus_wr && bus_addr == ADDR_W'(A_MASK)) mask_q <= bus_wdata[CTRL_W-1:0];
            if (bus_wr && bus_addr == ADDR_W'(A_CTRL))
                ctrl_q <= (ctrl_q & ~mask_q) | (bus_wdata[CTRL_W-1:0] & mask_q);
            for (int i = 0; i < FIELD_N; i++) begin
                if (grab_w)         buf_q[i] <= snap[i];
                else if (fld_we[i]) buf_q[i] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_W'(A_MASK))      bus_rdata = {6'd0, mask_q};
        else if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = {6'd0, ctrl_q};
        else if (bus_addr == ADDR_W'(A_UPD))  bus_rdata = {3'd0, pend_w[1], 3'd0, pend_w[0]};
        else begin
            for (int i = 0; i < FIELD_N; i++)
                if (bus_addr == ADDR_W'(A_TIME0 + i)) bus_rdata = buf_q[i];
        end
    end

    cal_rtc_xfer #(.SETTLE_CYC(SETTLE_CYC)) i_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_wr     (upd_wr),
        .upd_data   (bus_wdata),
        .busy       (busy),
        .pend       (pend_w),
        .load_pulse (load_w),
        .grab_pulse (grab_w),
        .done       (done_w)
    );

    cal_rtc_clock #(.YEAR_TOP(YEAR_TOP)) i_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1s),
        .load      (load_w),
        .load_val  (load_val),
        .live      (live_w),
        .min_pulse (min_event)
    );

endmodule

// File: rtl/cal_rtc_chk.sv
`timescale 1ns/1ps
module cal_rtc_chk #(
    parameter int SETTLE_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       min_event,
    input logic [1:0] pend,
    input logic       xfer_done,
    input logic       upd_wr,
    input logic       load,
    input logic       tick,
    input logic [5:0] sec,
    input logic [5:0] min,
    input logic [4:0] hour,
    input logic [6:0] wday
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 16'd1;
        else           run_q <= '0;
    end

    p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q <= 16'(SETTLE_CYC));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 16'(SETTLE_CYC + 1));

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pend == 2'b00);

    p_upd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && upd_wr && !xfer_done) |=> $stable(pend));

    p_min_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_event |=> !min_event);

    p_min_sec_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_event |-> sec == 6'd0);

    p_wday_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && sec == 6'd59 && min == 6'd59 && hour == 5'd23)
        |=> wday == {$past(wday[5:0]), $past(wday[6])});

endmodule

bind cal_rtc_regs cal_rtc_chk #(.SETTLE_CYC(SETTLE_CYC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .min_event (min_event),
    .pend      (pend_w),
    .xfer_done (done_w),
    .upd_wr    (upd_wr),
    .load      (load_w),
    .tick      (tick_1s),
    .sec       (live_w.sec),
    .min       (live_w.min),
    .hour      (live_w.hour),
    .wday      (live_w.wday)
);

// File: tb/test_cal_rtc_regs.sv
`timescale 1ns/1ps
module test_cal_rtc_regs;
    localparam int ADDR_W = 4;
    localparam int SETTLE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_1s = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              busy, min_event;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct {
        int         kind;   // 0 rdata, 1 busy, 2 min_event
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    cal_rtc_regs #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE)) i_cal_rtc_regs (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .min_event(min_event)
    );

    // Monitor: compare one expected item per cycle.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {7'd0, busy} : {7'd0, min_event};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push_check(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        push_check(0, exp, tag);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic tick_once();
        tick_1s = 1'b1;
        @(posedge clk); #1;
        tick_1s = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, mo, y, d);
        bus_write(4'h4, s); bus_write(4'h5, m); bus_write(4'h6, h);
        bus_write(4'h7, w); bus_write(4'h8, mo); bus_write(4'h9, y);
        bus_write(4'hA, d);
        bus_write(4'h2, 8'h01);
        wait_idle();
    endtask

    task automatic check_time(input logic [7:0] s, m, h, w, mo, y, d, input string tag);
        bus_write(4'h2, 8'h10);
        wait_idle();
        expect_rd(4'h4, s, {tag, " sec"});
        expect_rd(4'h5, m, {tag, " min"});
        expect_rd(4'h6, h, {tag, " hour"});
        expect_rd(4'h7, w, {tag, " wday"});
        expect_rd(4'h8, mo, {tag, " month"});
        expect_rd(4'h9, y, {tag, " year"});
        expect_rd(4'hA, d, {tag, " date"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        push_check(1, 8'h00, "R1 busy");
        expect_rd(4'h0, 8'h00, "R1 mask");
        expect_rd(4'h1, 8'h02, "R1 ctrl");
        expect_rd(4'h2, 8'h00, "R1 upd");
        expect_rd(4'h4, 8'h00, "R1 sec");
        expect_rd(4'h6, 8'h00, "R1 hour");
        expect_rd(4'h7, 8'h01, "R1 wday");
        expect_rd(4'h8, 8'h01, "R1 month");
        expect_rd(4'hA, 8'h01, "R1 date");

        // R2 masked control writes
        bus_write(4'h1, 8'h00);
        expect_rd(4'h1, 8'h02, "R2 mask zero");
        bus_write(4'h0, 8'h01);
        bus_write(4'h1, 8'h01);
        expect_rd(4'h1, 8'h03, "R2 bit0 only");
        expect_rd(4'h0, 8'h01, "R2 mask readback");
        bus_write(4'h0, 8'h03);
        bus_write(4'h1, 8'h02);
        expect_rd(4'h1, 8'h02, "R2 full mask");

        // R5 busy window and pending bits
        bus_write(4'h2, 8'h01);
        expect_rd(4'h2, 8'h01, "R5 pending write");
        for (int k = 0; k < SETTLE; k++) push_check(1, 8'h01, "R5 busy high");
        push_check(1, 8'h00, "R5 busy low");
        expect_rd(4'h2, 8'h00, "R5 self clear");

        // R3 R4 round trip, R11 addresses
        set_time(8'd58, 8'd59, 8'd23, 8'h40, 8'd2, 8'd23, 8'd28);
        check_time(8'd58, 8'd59, 8'd23, 8'h40, 8'd2, 8'd23, 8'd28, "R3 R11");

        // R7 minute event, R8 midnight, R9 Feb non-leap
        tick_once();
        push_check(2, 8'h00, "R7 no event at 59");
        tick_once();
        push_check(2, 8'h01, "R7 event");
        push_check(2, 8'h00, "R7 event one cycle");
        check_time(8'd0, 8'd0, 8'd0, 8'h01, 8'd3, 8'd23, 8'd1, "R8 R9 feb28");

        // R7 plain minute carry
        set_time(8'd59, 8'd10, 8'd5, 8'h02, 8'd6, 8'd10, 8'd10);
        tick_once();
        check_time(8'd0, 8'd11, 8'd5, 8'h02, 8'd6, 8'd10, 8'd10, "R7 min carry");

        // R9 leap February
        set_time(8'd59, 8'd59, 8'd23, 8'h04, 8'd2, 8'd24, 8'd28);
        tick_once();
        check_time(8'd0, 8'd0, 8'd0, 8'h08, 8'd2, 8'd24, 8'd29, "R9 leap");

        // R9 year wrap, R8 rotation
        set_time(8'd59, 8'd59, 8'd23, 8'h20, 8'd12, 8'd99, 8'd31);
        tick_once();
        check_time(8'd0, 8'd0, 8'd0, 8'h40, 8'd1, 8'd0, 8'd1, "R9 year wrap");

        // R9 thirty-day month
        set_time(8'd59, 8'd59, 8'd23, 8'h01, 8'd4, 8'd5, 8'd30);
        tick_once();
        check_time(8'd0, 8'd0, 8'd0, 8'h02, 8'd5, 8'd5, 8'd1, "R9 april");

        // R10 12-hour format
        bus_write(4'h1, 8'h00);
        expect_rd(4'h1, 8'h00, "R10 ctrl 12h");
        set_time(8'd10, 8'd20, 8'h47, 8'h02, 8'd5, 8'd30, 8'd15);
        bus_write(4'h1, 8'h02);
        check_time(8'd10, 8'd20, 8'h13, 8'h02, 8'd5, 8'd30, 8'd15, "R10 pm to 24h");
        bus_write(4'h1, 8'h00);
        check_time(8'd10, 8'd20, 8'h47, 8'h02, 8'd5, 8'd30, 8'd15, "R10 24h to pm");
        set_time(8'd0, 8'd0, 8'h0C, 8'h01, 8'd1, 8'd1, 8'd1);
        check_time(8'd0, 8'd0, 8'h0C, 8'h01, 8'd1, 8'd1, 8'd1, "R10 midnight 12h");
        bus_write(4'h1, 8'h02);
        check_time(8'd0, 8'd0, 8'h00, 8'h01, 8'd1, 8'd1, 8'd1, "R10 midnight 24h");

        // R4 both bits: commit only
        bus_write(4'h2, 8'h11);
        expect_rd(4'h2, 8'h01, "R4 both bits");
        wait_idle();

        // R6 ignored update write during busy
        bus_write(4'h2, 8'h10);
        bus_write(4'h2, 8'h01);
        expect_rd(4'h2, 8'h10, "R6 ignored");
        wait_idle();
        expect_rd(4'h2, 8'h00, "R6 no late commit");

        // R11 unmapped addresses
        expect_rd(4'h3, 8'h00, "R11 gap");
        expect_rd(4'hF, 8'h00, "R11 top");

        @(posedge clk); #1;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule